// File: doc/BRIEF.md
# Multi-Function Configuration Access Gate

This block sits in front of the configuration spaces of a device that can present up to three functions on a PCI-style target port. At power-up no target access can succeed, because the local firmware has not yet prepared the configuration headers. While the block is in this state, it answers every incoming target access with a Retry, whatever function number the access names.

The local processor has a small control register. A two-bit count field in it selects how many functions are exposed, and a set-once ready flag releases the target port. During boot, and only then, the local side may also rewrite the class code that each function presents. When the ready flag goes high, the count field and the class codes are frozen until the next reset.

After release, the block claims an access whose function number falls inside the enabled range, which always starts at zero and is contiguous. It returns that function's class code with the claim. An access to a function number outside the range gets neither a claim nor a Retry, so the requester sees a master abort.

Top module: `pciCfgGate`

## Requirements
- R1: After reset, the ready flag is 0, the count field is 00, ctlRdData is all zero, every class code holds its default (24'h040100), and tgtRetry and tgtClaim are low.
- R2: While the ready flag is 0, a cycle with tgtReq high gives tgtRetry=1 and tgtClaim=0 on the next clock edge, for any tgtFunc value.
- R3: A control write with bit 2 set makes the ready flag (ctlRdData bit 2) 1. Once the flag is 1, no control write clears it. Only reset does.
- R4: The count field (control bits 1:0) takes the written value only if the ready flag was 0 before the write. A write that also sets the ready flag updates the count. Later writes leave the count unchanged.
- R5: With the ready flag at 1, an access to function f is claimed (tgtClaim=1, tgtRetry=0 on the next edge) exactly when f < n, where n is 1, 2, 3 or 3 for count codes 00, 01, 10 or 11.
- R6: With the ready flag at 1, an access to a function outside the enabled range leaves both tgtRetry and tgtClaim low. tgtRetry and tgtClaim are never high together.
- R7: Control bits 15 to 3 always read as zero, and values written to them have no effect.
- R8: In the cycle tgtClaim is high, tgtRdData carries the current class code of the claimed function. In every other cycle it is zero.
- R9: A class code write to function k (k < 3) is stored only while the ready flag is 0. After that, class writes, and writes naming function 3, change nothing.
- R10: A cycle without tgtReq gives tgtRetry=0 and tgtClaim=0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Local control register write strobe |
| ctlWrData | input | 16 | Local control write data (bit 2 ready, bits 1:0 count code) |
| ctlRdData | output | 16 | Current control register value |
| classWrEn | input | 1 | Local class code write strobe |
| classWrFunc | input | 2 | Function whose class code is written |
| classWrData | input | 24 | New class code |
| tgtReq | input | 1 | Target access presented this cycle |
| tgtFunc | input | 2 | Function number addressed by the access |
| tgtRetry | output | 1 | Access terminated with Retry (registered) |
| tgtClaim | output | 1 | Access claimed (registered) |
| tgtRdData | output | 24 | Class code of the claimed function, else zero |

## Verification
A control or class write takes effect at the clock edge that samples it, and ctlRdData shows the new state combinationally right after that edge. A target response is registered, so it appears one edge after the request and lasts one cycle. The bench drives every input on the falling edge. It samples ctlRdData on the next falling edge after a write, and samples the three response outputs on the falling edge one full cycle after tgtReq was raised, which is exactly where that one-cycle response lies. Its expectations come from a small model of the ready flag, the count code and the class codes, which it updates at the same edges.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  localparam int FUNC_W = 2;   // function number and count code width

  // strobes and state that the control half hands to the datapath half
  typedef struct packed {
    logic              classWe;
    logic [FUNC_W-1:0] classFunc;
    logic              locked;
    logic              rspRetry;
    logic              rspClaim;
    logic [FUNC_W-1:0] rspFunc;
  } pcgStrobe_t;

  // number of functions exposed for a count code; code 11 behaves as 10
  function automatic logic [FUNC_W:0] codeToCount(input logic [FUNC_W-1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd3;
    endcase
  endfunction

endpackage

// File: rtl/pcg_ctrl.sv
module pcg_ctrl
  import pcg_pkg::*;
#(
  parameter int CTL_W     = 16,
  parameter int NUM_FUNCS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [CTL_W-1:0]  ctlWrData,
  output logic [CTL_W-1:0]  ctlRdData,
  input  logic              classWrEn,
  input  logic [FUNC_W-1:0] classWrFunc,
  input  logic              tgtReq,
  input  logic [FUNC_W-1:0] tgtFunc,
  output pcgStrobe_t        strb
);

  localparam int READY_BIT = 2;
  localparam logic [FUNC_W:0] FUNC_LIMIT = (FUNC_W+1)'(NUM_FUNCS);

  logic              readyQ;
  logic [FUNC_W-1:0] cntQ;
  logic [FUNC_W:0]   enabledCnt;
  logic              funcInRange;
  logic              classFuncOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      cntQ   <= '0;
    end else if (ctlWrEn) begin
      if (!readyQ) cntQ <= ctlWrData[FUNC_W-1:0];
      if (ctlWrData[READY_BIT]) readyQ <= 1'b1;
    end
  end

  // enabled count limited by how many configuration spaces exist
  always_comb begin
    enabledCnt = codeToCount(cntQ);
    if (enabledCnt > FUNC_LIMIT) enabledCnt = FUNC_LIMIT;
    funcInRange = ({1'b0, tgtFunc} < enabledCnt);
    classFuncOk = ({1'b0, classWrFunc} < FUNC_LIMIT);
  end

  always_comb begin
    strb.classWe   = classWrEn && !readyQ && classFuncOk;
    strb.classFunc = classWrFunc;
    strb.locked    = readyQ;
    strb.rspRetry  = tgtReq && !readyQ;
    strb.rspClaim  = tgtReq && readyQ && funcInRange;
    strb.rspFunc   = tgtFunc;
  end

  always_comb begin
    ctlRdData            = '0;
    ctlRdData[FUNC_W-1:0] = cntQ;
    ctlRdData[READY_BIT] = readyQ;
  end

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    readyQ |=> readyQ); // R3
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    readyQ |=> $stable(cntQ)); // R4
  AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && (|ctlWrData[CTL_W-1:READY_BIT+1])) |=> (ctlRdData[CTL_W-1:READY_BIT+1] == '0)); // R7

endmodule

// File: rtl/pcg_dpath.sv
module pcg_dpath
  import pcg_pkg::*;
#(
  parameter int              NUM_FUNCS = 3,
  parameter int              CLASS_W   = 24,
  parameter logic [CLASS_W-1:0] DEF_CLASS = 24'h040100
) (
  input  logic               clk,
  input  logic               rstN,
  input  pcgStrobe_t         strb,
  input  logic [CLASS_W-1:0] classWrData,
  output logic               tgtRetry,
  output logic               tgtClaim,
  output logic [CLASS_W-1:0] tgtRdData
);

  logic [CLASS_W-1:0] classQ [NUM_FUNCS];
  logic [CLASS_W-1:0] rdSel;

  for (genvar g = 0; g < NUM_FUNCS; g++) begin : gClass
    always_ff @(posedge clk) begin
      if (!rstN)
        classQ[g] <= DEF_CLASS;
      else if (strb.classWe && strb.classFunc == FUNC_W'(g))
        classQ[g] <= classWrData;
    end

    AST_CLASS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
      strb.locked |=> $stable(classQ[g])); // R9
  end

  always_comb begin
    rdSel = '0;
    for (int i = 0; i < NUM_FUNCS; i++)
      if (strb.rspFunc == FUNC_W'(i)) rdSel = classQ[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtRetry  <= 1'b0;
      tgtClaim  <= 1'b0;
      tgtRdData <= '0;
    end else begin
      tgtRetry  <= strb.rspRetry;
      tgtClaim  <= strb.rspClaim;
      tgtRdData <= strb.rspClaim ? rdSel : '0;
    end
  end

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    !(tgtRetry && tgtClaim)); // R6

endmodule

// File: rtl/pciCfgGate.sv
module pciCfgGate
  import pcg_pkg::*;
#(
  parameter int                 NUM_FUNCS = 3,
  parameter int                 CTL_W     = 16,
  parameter int                 CLASS_W   = 24,
  parameter logic [CLASS_W-1:0] DEF_CLASS = 24'h040100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctlWrEn,
  input  logic [CTL_W-1:0]   ctlWrData,
  output logic [CTL_W-1:0]   ctlRdData,
  input  logic               classWrEn,
  input  logic [FUNC_W-1:0]  classWrFunc,
  input  logic [CLASS_W-1:0] classWrData,
  input  logic               tgtReq,
  input  logic [FUNC_W-1:0]  tgtFunc,
  output logic               tgtRetry,
  output logic               tgtClaim,
  output logic [CLASS_W-1:0] tgtRdData
);

  pcgStrobe_t strb;

  pcg_ctrl #(.CTL_W(CTL_W), .NUM_FUNCS(NUM_FUNCS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .ctlRdData(ctlRdData),
    .classWrEn(classWrEn), .classWrFunc(classWrFunc),
    .tgtReq(tgtReq), .tgtFunc(tgtFunc),
    .strb(strb)
  );

  pcg_dpath #(.NUM_FUNCS(NUM_FUNCS), .CLASS_W(CLASS_W), .DEF_CLASS(DEF_CLASS)) u_dpath (
    .clk(clk), .rstN(rstN),
    .strb(strb), .classWrData(classWrData),
    .tgtRetry(tgtRetry), .tgtClaim(tgtClaim), .tgtRdData(tgtRdData)
  );

  AST_RETRY_UNREADY: assert property (@(posedge clk) disable iff (!rstN)
    (tgtReq && !ctlRdData[2]) |=> (tgtRetry && !tgtClaim)); // R2
  AST_SINGLE_FUNC: assert property (@(posedge clk) disable iff (!rstN)
    (tgtReq && ctlRdData[2] && ctlRdData[1:0] == 2'b00 && tgtFunc != 2'd0) |=> !tgtClaim); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !tgtReq |=> (!tgtRetry && !tgtClaim)); // R10
  AST_DATA_ONLY_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    !tgtClaim |-> (tgtRdData == '0)); // R8

endmodule

// File: tb/pciCfgGate_tb.sv
module pciCfgGate_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ctlWrEn;
  logic [15:0] ctlWrData;
  logic [15:0] ctlRdData;
  logic        classWrEn;
  logic [1:0]  classWrFunc;
  logic [23:0] classWrData;
  logic        tgtReq;
  logic [1:0]  tgtFunc;
  logic        tgtRetry;
  logic        tgtClaim;
  logic [23:0] tgtRdData;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // model state
  bit          mReady;
  logic [1:0]  mCnt;
  logic [23:0] mClass [3];

  always #2.5 clk = ~clk;   // 200 MHz

  pciCfgGate u_dut (
    .clk(clk), .rstN(rstN),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .ctlRdData(ctlRdData),
    .classWrEn(classWrEn), .classWrFunc(classWrFunc), .classWrData(classWrData),
    .tgtReq(tgtReq), .tgtFunc(tgtFunc),
    .tgtRetry(tgtRetry), .tgtClaim(tgtClaim), .tgtRdData(tgtRdData)
  );

  function automatic int enabledOf(input logic [1:0] code);
    return (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 3;
  endfunction

  function automatic logic [15:0] expCtl();
    return {13'b0, mReady, mCnt};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; ctlWrEn = 0; classWrEn = 0; tgtReq = 0;
    ctlWrData = '0; classWrFunc = '0; classWrData = '0; tgtFunc = '0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mReady = 0; mCnt = 2'b00;
    for (int i = 0; i < 3; i++) mClass[i] = 24'h040100;
  endtask

  task automatic ctlWrite(input logic [15:0] d);
    @(negedge clk);
    ctlWrEn = 1'b1; ctlWrData = d;
    @(negedge clk);
    ctlWrEn = 1'b0;
    if (!mReady) mCnt = d[1:0];
    if (d[2]) mReady = 1;
    check("R3/R4/R7 ctl readback", {16'b0, ctlRdData}, {16'b0, expCtl()});
  endtask

  task automatic classWrite(input logic [1:0] f, input logic [23:0] d);
    @(negedge clk);
    classWrEn = 1'b1; classWrFunc = f; classWrData = d;
    @(negedge clk);
    classWrEn = 1'b0;
    if (!mReady && f != 2'd3) mClass[f] = d;
  endtask

  task automatic access(input logic [1:0] f);
    bit expClaim;
    @(negedge clk);
    tgtReq = 1'b1; tgtFunc = f;
    @(negedge clk);
    tgtReq = 1'b0;
    expClaim = mReady && (int'(f) < enabledOf(mCnt));
    check(mReady ? "R5/R6 retry" : "R2 retry", {31'b0, tgtRetry}, {31'b0, !mReady});
    check(mReady ? "R5/R6 claim" : "R2 claim", {31'b0, tgtClaim}, {31'b0, expClaim});
    check("R8/R9 class data", {8'b0, tgtRdData}, expClaim ? {8'b0, mClass[f]} : 32'b0);
  endtask

  task automatic idleCheck();
    @(negedge clk);
    check("R10 idle retry", {31'b0, tgtRetry}, 32'b0);
    check("R10 idle claim", {31'b0, tgtClaim}, 32'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357));
    rstN = 1'b0;
    doReset();
    // R1 reset state
    check("R1 ctl after reset", {16'b0, ctlRdData}, 32'b0);
    check("R1 retry after reset", {31'b0, tgtRetry}, 32'b0);
    check("R1 claim after reset", {31'b0, tgtClaim}, 32'b0);
    idleCheck();

    // R2 retry before ready for every function number
    for (int f = 0; f < 4; f++) access(2'(f));
    // R4 count rewritable before ready; R7 reserved bits ignored
    ctlWrite(16'hFFF9);          // count 01, ready 0, reserved set
    ctlWrite(16'h0002);          // count 10
    access(2'd1);                // still retry, R2

    // for each count code, release and probe all functions
    for (int code = 0; code < 4; code++) begin
      doReset();
      access(2'd0);                               // R1 default class invisible, R2
      for (int f = 0; f < 4; f++) classWrite(2'(f), 24'($urandom));  // R9 boot writes
      ctlWrite({13'($urandom), 1'b1, 2'(code)});  // R3 set ready with count
      for (int f = 0; f < 4; f++) access(2'(f));  // R5/R6/R8
      ctlWrite(16'h0000);                          // R3 cannot clear
      ctlWrite({13'h0, 1'b0, 2'(~code)});          // R4 count frozen
      classWrite(2'd0, 24'hABCDEF);                // R9 ignored after ready
      for (int f = 0; f < 4; f++) access(2'(f));
      idleCheck();                                  // R10
    end

    // R3 only reset clears ready
    doReset();
    check("R3 ready cleared by reset", {16'b0, ctlRdData}, 32'b0);
    access(2'd2);

    // random mix
    doReset();
    for (int n = 0; n < 300; n++) begin
      case ($urandom % 5)
        0: ctlWrite(($urandom % 8 == 0) ? 16'($urandom) : (16'($urandom) & 16'hFFFB));
        1: classWrite(2'($urandom), 24'($urandom));
        2, 3: access(2'($urandom));
        default: idleCheck();
      endcase
      if ($urandom % 60 == 0) doReset();
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule